// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor request port and a word-addressed memory port. Each word address is split into three fields: a tag (upper bits), a set index (middle bits) and a word offset (low bits). The set index selects one of the sets. The four ways of that set are compared in parallel against the tag. A hit returns the addressed word, or stores into it, in the same cycle that the request is presented.

On a miss the processor port stays stalled while the cache brings in the whole four-word block that holds the referenced word. A way is chosen to receive the block. If the current occupant of that way is dirty, its four words are first written back to memory. The new block is then read one word at a time, and the held request completes as an ordinary hit. The receiving way is either the lowest-numbered empty way of the set, or, when the set is full, the way named by a three-bit tree of pseudo-LRU bits kept for each set. Stores only ever modify the cached copy and mark the line dirty.

The memory port moves one word per request/acknowledge handshake. The acknowledge can arrive after any number of cycles.

Top module: `sa4_cache`

## Requirements
- R1: After reset no line is valid, every pseudo-LRU bit is zero, `mem_req` is low, and the first request to any address misses, so `cpu_ready` stays low in that request's first cycle.
- R2: A request hits only when a way of the selected set is valid and holds the address tag. Set index = address bits [OFF_W+SET_W-1:OFF_W], tag = the upper TAG_W bits. On a hit `cpu_ready` rises in the cycle the request is presented, `cpu_rdata` is the word selected by the offset bits [OFF_W-1:0], and at most one way matches.
- R3: On a miss `cpu_ready` stays low while the block is fetched. The cache issues exactly four reads, at word offsets 0, 1, 2, 3 in that order, of the block {tag, set}. The held request then completes as a hit.
- R4: A store that hits updates only the cached word and marks the line dirty. It causes no memory transfer, and the memory copy keeps its old value.
- R5: When the chosen victim is valid and dirty, the cache first writes its four words (offsets 0 to 3, at address {old tag, set}) with the latest stored values. Only then does it issue any read.
- R6: When the chosen victim is empty or clean, no memory write occurs for that miss.
- R7: While a set has an empty way, a miss fills the lowest-numbered empty way, and no valid line of the set is displaced.
- R8: On each hit or fill of way w, the pair bit is set to point at the pair that does not contain w, and that pair's inner bit is set to point at the other way of w's pair. In a full set the victim is found by following the pair bit and then that pair's inner bit.
- R9: While `mem_req` is high and no acknowledge has arrived, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged. Acknowledge latencies of zero to three idle cycles are all tolerated.
- R10: After one miss, all four words of the fetched block hit without any memory transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rdata | input | DATA_W | Fill read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer of the current word done |

## Verification
The bench builds the cache with a 10-bit word address, four sets and four-word blocks. This leaves a 6-bit tag and only sixteen lines in total. With so little capacity, a short address sweep over eight tags per set keeps every set full. Victims are therefore chosen by the pseudo-LRU tree almost all the time, and dirty write-backs and clean evictions both occur hundreds of times. The memory responder varies its acknowledge delay from zero to three idle cycles, so the stability of held transfers is exercised at every latency.

// File: rtl/cache_pkg.sv
package cache_pkg;

  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} cstate_t;

  // tree[0]: older pair (0 = ways 0/1, 1 = ways 2/3)
  // tree[1]: older way inside pair 0, tree[2]: older way inside pair 1
  typedef logic [2:0] plru_t;

  function automatic plru_t plru_touch(input plru_t cur, input logic [WAY_W-1:0] w);
    plru_t nxt;
    nxt    = cur;
    nxt[0] = ~w[1];
    if (w[1]) nxt[2] = ~w[0];
    else      nxt[1] = ~w[0];
    return nxt;
  endfunction

  function automatic logic [WAY_W-1:0] plru_pick(input plru_t cur);
    return cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};
  endfunction

  function automatic logic [WAY_W-1:0] first_free(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!v[i]) r = WAY_W'(i);
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] onehot_index(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = 0; i < WAYS; i++)
      if (v[i]) r = WAY_W'(i);
    return r;
  endfunction

endpackage

// File: rtl/cache_lookup.sv
module cache_lookup
  import cache_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  way_valid,
  input  logic [TAG_W-1:0] way_tag [WAYS],
  input  logic [TAG_W-1:0] want_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way
);

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = way_valid[g] && (way_tag[g] == want_tag);
  end

  assign hit     = |hit_vec;
  assign hit_way = onehot_index(hit_vec);

  // R2: a tag can live in at most one way of a set
  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/cache_plru.sv
module cache_plru
  import cache_pkg::*;
#(
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  set_valid,
  input  logic [SET_W-1:0] look_set,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way,
  output logic             victim_free
);

  localparam int SETS = 1 << SET_W;

  plru_t tree_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[touch_set] <= plru_touch(tree_q[touch_set], touch_way);
    end
  end

  assign victim_free = ~&set_valid;
  assign victim_way  = victim_free ? first_free(set_valid) : plru_pick(tree_q[look_set]);

  // R7: an empty way is always preferred
  p_free_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    victim_free |-> !set_valid[victim_way]);

  // R8: a just-used way is never the next tree victim of its set
  p_touch_away_r8: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> plru_pick(tree_q[$past(touch_set)]) != $past(touch_way));

endmodule

// File: rtl/sa4_cache.sv
module sa4_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int SET_W  = 2,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int SETS  = 1 << SET_W;
  localparam int WORDS = 1 << OFF_W;
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_WORD = '1;

  // address fields
  logic [TAG_W-1:0] a_tag;
  logic [SET_W-1:0] a_set;
  logic [OFF_W-1:0] a_off;
  assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_set = cpu_addr[OFF_W +: SET_W];
  assign a_off = cpu_addr[OFF_W-1:0];

  // line storage
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [TAG_W-1:0]  tag_q   [WAYS][SETS];
  logic [DATA_W-1:0] data_q  [WAYS][SETS][WORDS];

  // miss context
  cstate_t          st_q;
  logic [WAY_W-1:0] m_way;
  logic [SET_W-1:0] m_set;
  logic [TAG_W-1:0] m_tag;
  logic [TAG_W-1:0] m_old_tag;
  logic [OFF_W-1:0] cnt_q;

  // lookup
  logic [TAG_W-1:0] set_tags [WAYS];
  logic [WAYS-1:0]  lk_vec;
  logic             lk_hit;
  logic [WAY_W-1:0] lk_way;

  always_comb begin
    for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[w][a_set];
  end

  cache_lookup #(.TAG_W(TAG_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .way_valid (valid_q[a_set]),
    .way_tag   (set_tags),
    .want_tag  (a_tag),
    .hit_vec   (lk_vec),
    .hit       (lk_hit),
    .hit_way   (lk_way)
  );

  // named events
  logic acc_hit, miss_start, fill_write, fill_done, wb_step;
  logic touch_en;
  logic [SET_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;
  logic [WAY_W-1:0] victim;
  logic             victim_free;
  logic             victim_dirty;

  assign acc_hit    = (st_q == S_IDLE) && cpu_req && lk_hit;
  assign miss_start = (st_q == S_IDLE) && cpu_req && !lk_hit;
  assign fill_write = (st_q == S_FILL) && mem_ack;
  assign fill_done  = fill_write && (cnt_q == LAST_WORD);
  assign wb_step    = (st_q == S_WB) && mem_ack;
  assign touch_en   = acc_hit || fill_done;
  assign touch_set  = acc_hit ? a_set  : m_set;
  assign touch_way  = acc_hit ? lk_way : m_way;

  cache_plru #(.SET_W(SET_W)) u_plru (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_valid   (valid_q[a_set]),
    .look_set    (a_set),
    .touch_en    (touch_en),
    .touch_set   (touch_set),
    .touch_way   (touch_way),
    .victim_way  (victim),
    .victim_free (victim_free)
  );

  assign victim_dirty = valid_q[a_set][victim] && dirty_q[a_set][victim];

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      m_way     <= '0;
      m_set     <= '0;
      m_tag     <= '0;
      m_old_tag <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (miss_start) begin
          m_way     <= victim;
          m_set     <= a_set;
          m_tag     <= a_tag;
          m_old_tag <= tag_q[victim][a_set];
          cnt_q     <= '0;
          st_q      <= victim_dirty ? S_WB : S_FILL;
        end
        S_WB: if (mem_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_WORD) st_q <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_WORD) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // line state bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (fill_done) begin
        valid_q[m_set][m_way] <= 1'b1;
        dirty_q[m_set][m_way] <= 1'b0;
      end
      if (acc_hit && cpu_we) dirty_q[a_set][lk_way] <= 1'b1;
    end
  end

  // tags and data (no reset needed)
  always_ff @(posedge clk) begin
    if (fill_done) tag_q[m_way][m_set] <= m_tag;
    if (fill_write) data_q[m_way][m_set][cnt_q] <= mem_rdata;
    if (acc_hit && cpu_we) data_q[lk_way][a_set][a_off] <= cpu_wdata;
  end

  // ports
  assign cpu_ready = acc_hit;
  assign cpu_rdata = data_q[lk_way][a_set][a_off];
  assign mem_req   = (st_q != S_IDLE);
  assign mem_we    = (st_q == S_WB);
  assign mem_addr  = {(st_q == S_WB) ? m_old_tag : m_tag, m_set, cnt_q};
  assign mem_wdata = data_q[m_way][m_set][cnt_q];

  // R3: once the fill finishes the requested block is present
  p_fill_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> valid_q[m_set][m_way] && (tag_q[m_way][m_set] == m_tag));

  // R4: a store hit leaves its line dirty
  p_store_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |=> dirty_q[$past(a_set)][$past(lk_way)]);

  // R5: only dirty lines are written back
  p_wb_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> dirty_q[m_set][m_way]);

  // R6: a clean or empty victim goes straight to the fill reads
  p_clean_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_start && !victim_dirty) |=> (mem_req && !mem_we));

  // R9: a pending transfer holds still until acknowledged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata)));

endmodule

// File: tb/tb_sa4_cache.sv
`timescale 1ns/1ps
module tb_sa4_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [9:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sa4_cache #(.ADDR_W(10), .DATA_W(32), .SET_W(2), .OFF_W(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] seed_word(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // memory responder with varying latency
  logic [31:0] mem_arr [1024];
  logic [31:0] gold    [1024];
  logic [9:0]  rd_a [16];
  logic [9:0]  wr_a [16];
  int nrd, nwr, wcnt, lat;
  bit order_bad, hold_bad, waiting;
  logic [9:0]  f_addr;
  logic        f_we;
  logic [31:0] f_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt = 0; lat = 0; waiting = 0;
      for (int i = 0; i < 1024; i++) mem_arr[i] <= seed_word(i);
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (!waiting) begin
        waiting = 1; f_addr = mem_addr; f_we = mem_we; f_wd = mem_wdata;
      end else if (mem_addr !== f_addr || mem_we !== f_we || (f_we && mem_wdata !== f_wd)) begin
        hold_bad = 1;
      end
      if (wcnt < lat) wcnt++;
      else begin
        mem_ack <= 1'b1;
        wcnt = 0; waiting = 0; lat = (lat + 1) % 4;
        if (mem_we) begin
          mem_arr[mem_addr] <= mem_wdata;
          wr_a[nwr % 16] = mem_addr; nwr++;
          if (nrd > 0) order_bad = 1;
        end else begin
          mem_rdata <= mem_arr[mem_addr];
          rd_a[nrd % 16] = mem_addr; nrd++;
        end
      end
    end
  end

  // reference model of placement state
  bit mv [4][4];
  bit md [4][4];
  int mt [4][4];
  bit older_pair [4];
  bit older_in   [4][2];

  function automatic int pick(input int s);
    for (int w = 0; w < 4; w++) if (!mv[s][w]) return w;
    return 2 * int'(older_pair[s]) + int'(older_in[s][older_pair[s]]);
  endfunction

  task automatic touch(input int s, input int w);
    older_pair[s]      = (w / 2 == 0);
    older_in[s][w / 2] = (w % 2 == 0);
  endtask

  task automatic do_access(input bit we, input logic [9:0] a, input logic [31:0] wd,
                           input string rq, output bit was_hit);
    int s, t, hw, v, cyc;
    bit ph, exp_wb;
    int old_t;
    logic [31:0] got;
    logic [9:0] ea;
    s = int'(a[3:2]); t = int'(a[9:4]);
    ph = 0; hw = 0;
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) begin ph = 1; hw = w; end
    v = pick(s);
    exp_wb = !ph && mv[s][v] && md[s][v];
    old_t = mt[s][v];
    nrd = 0; nwr = 0; order_bad = 0; hold_bad = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0;
    #1;
    while (!cpu_ready && cyc < 3000) begin @(negedge clk); #1; cyc++; end
    got = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
    was_hit = (cyc == 0);
    chk(cyc < 3000, "R3", "request completes", cyc, 0);
    chk(was_hit == ph, rq, "hit in first cycle", {31'd0, was_hit}, {31'd0, ph});
    if (!we) chk(got == gold[a], "R2", "load word", got, gold[a]);
    chk(nrd == (ph ? 0 : 4), "R3", "fill read count", nrd, ph ? 0 : 4);
    if (!ph) for (int i = 0; i < 4; i++) begin
      ea = {t[5:0], s[1:0], i[1:0]};
      chk(rd_a[i] == ea, "R3", "fill read address", {22'd0, rd_a[i]}, {22'd0, ea});
    end
    chk(nwr == (exp_wb ? 4 : 0), exp_wb ? "R5" : "R6", "write-back count", nwr, exp_wb ? 4 : 0);
    if (exp_wb) for (int i = 0; i < 4; i++) begin
      ea = {old_t[5:0], s[1:0], i[1:0]};
      chk(wr_a[i] == ea, "R5", "write-back address", {22'd0, wr_a[i]}, {22'd0, ea});
      chk(mem_arr[ea] == gold[ea], "R5", "write-back data", mem_arr[ea], gold[ea]);
    end
    chk(!order_bad, "R5", "writes precede reads", {31'd0, order_bad}, 0);
    chk(!hold_bad, "R9", "held transfer stable", {31'd0, hold_bad}, 0);
    if (ph) touch(s, hw);
    else begin
      mv[s][v] = 1; mt[s][v] = t; md[s][v] = 0; touch(s, v); hw = v;
    end
    if (we) begin md[s][hw] = 1; gold[a] = wd; end
  endtask

  task automatic t_reset;
    rst_n = 0;
    for (int s = 0; s < 4; s++) begin
      older_pair[s] = 0; older_in[s][0] = 0; older_in[s][1] = 0;
      for (int w = 0; w < 4; w++) begin mv[s][w] = 0; md[s][w] = 0; mt[s][w] = 0; end
    end
    for (int i = 0; i < 1024; i++) gold[i] = seed_word(i);
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cpu_ready == 0, "R1", "ready low after reset", {31'd0, cpu_ready}, 0);
    chk(mem_req == 0, "R1", "memory idle after reset", {31'd0, mem_req}, 0);
  endtask

  task automatic t_block;
    bit h;
    do_access(0, 10'h013, '0, "R1", h);  // cold miss
    do_access(0, 10'h010, '0, "R10", h);
    do_access(0, 10'h011, '0, "R10", h);
    do_access(0, 10'h012, '0, "R10", h);
    chk(h == 1, "R10", "neighbour hit", {31'd0, h}, 1);
  endtask

  task automatic t_store;
    bit h;
    do_access(1, 10'h012, 32'hDEAD_BEEF, "R4", h);
    chk(h == 1 && nwr == 0 && nrd == 0, "R4", "store hit without traffic", nwr + nrd, 0);
    chk(mem_arr[10'h012] == seed_word(10'h012), "R4", "memory copy unchanged",
        mem_arr[10'h012], seed_word(10'h012));
    do_access(0, 10'h012, '0, "R2", h);
  endtask

  task automatic t_ways;
    bit h;
    do_access(0, 10'h020, '0, "R7", h);
    do_access(0, 10'h030, '0, "R7", h);
    do_access(0, 10'h040, '0, "R7", h);
    // all four tags must still be resident
    do_access(0, 10'h011, '0, "R7", h);
    do_access(0, 10'h021, '0, "R7", h);
    do_access(0, 10'h031, '0, "R7", h);
    do_access(0, 10'h041, '0, "R7", h);
    // full set: tree picks way 0 (tag 1, dirty)
    do_access(0, 10'h050, '0, "R8", h);
    chk(nwr == 4, "R5", "dirty victim written", nwr, 4);
    // tree now picks way 2 (tag 3, clean)
    do_access(0, 10'h060, '0, "R8", h);
    chk(nwr == 0, "R6", "clean victim dropped", nwr, 0);
    do_access(0, 10'h032, '0, "R8", h);
    chk(h == 0, "R8", "evicted tag misses", {31'd0, h}, 0);
    do_access(0, 10'h022, '0, "R8", h);
  endtask

  task automatic t_sweep;
    logic [15:0] lf;
    bit h;
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_access(lf[9] & lf[8], {3'b000, lf[6:0]}, {lf, ~lf}, "R8", h);
    end
  endtask

  initial begin
    t_reset;
    t_block;
    t_store;
    t_ways;
    t_sweep;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule